// File: doc/BRIEF.md
# Triggered Dual-Channel Burst Capture Controller

This block records a fixed-length burst from two 12-bit converter channels into one on-chip buffer per channel. Capture runs at the converter clock divided by a power of two from 1 to 128. Capture is started in one of three ways. In manual mode a host start command starts it. In single-trigger mode a comparator crossing starts it, but only after the host has armed the block. In periodic mode a comparator crossing starts it, and the block re-arms by itself each time the host has drained the previous burst.

Each sample is widened to a 16-bit word with zeros in the top four bits. The host drains each channel through a show-ahead read port, one word per request. Once every captured word has been read, or when a clear command arrives, the buffers return to the empty state and a new burst may begin. While a burst is held, no further capture can start. A comparator crossing during that time is dropped, not saved.

Top module: `burst_capture_ctrl`

## Requirements
- R1: After reset, `capture_we` is 0, `buf_full` is 0 and `rd_empty` is 1 for both channels.
- R2: With `mode` = 0 (manual; 3 behaves the same), `host_start` high while the buffers are empty opens the capture window (`capture_we` = 1) on the next cycle. `trig_in` has no effect in this mode.
- R3: The sample ratio is 2^`rate_sel`. Within the capture window a sample is taken on every ratio-th cycle, and the first is taken on the ratio-th cycle of the window.
- R4: Each stored word is the 12-bit input zero-extended to 16 bits. Words are read out in capture order.
- R5: With `dual_en` = 1, both channels are written on the same sample strobe. With `dual_en` = 0 (the value at capture start), only channel A (`rd_sel` = 0) is written and channel B (`rd_sel` = 1) reads as empty.
- R6: On the edge that writes the DEPTH-th sample, `capture_we` falls and `buf_full` rises.
- R7: With `mode` = 1 (single trigger), `host_start` while the buffers are empty arms the block. A `trig_in` high for one cycle while armed and empty is latched, and capture opens one cycle later. A trigger while unarmed is ignored. Starting a capture disarms the block.
- R8: The latched trigger is cleared when a burst completes. A trigger that arrives while a burst is being captured or held is ignored, and it does not start a later capture.
- R9: With `mode` = 2 (periodic), the block is armed whenever the buffers are empty. After a drain, the next capture waits for a new trigger.
- R10: While a burst is held, `rd_data` shows the oldest unread word of the channel chosen by `rd_sel`. `rd_req` pops that word. `rd_empty` is 1 when that channel has nothing left to read, and it is always 1 outside the held state.
- R11: `buf_full` stays 1 until every written channel has been fully read, and drops on the cycle after that. A `clear` pulse empties both buffers and returns the block to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 manual, 1 single trigger, 2 periodic, 3 manual |
| dual_en | input | 1 | 1 = capture both channels, 0 = channel A only |
| rate_sel | input | RATE_W (3) | Divider exponent; sample ratio 2^rate_sel |
| host_start | input | 1 | Host start (manual) or arm (single trigger) |
| trig_in | input | 1 | Comparator output, high when input exceeds threshold |
| clear | input | 1 | Discard held data and return to idle |
| ch_a_in | input | SAMPLE_W (12) | Channel A sample |
| ch_b_in | input | SAMPLE_W (12) | Channel B sample |
| rd_req | input | 1 | Pop one word from the selected channel |
| rd_sel | input | 1 | Read channel select, 0 = A, 1 = B |
| rd_data | output | WORD_W (16) | Oldest unread word of the selected channel |
| rd_empty | output | 1 | Selected channel has nothing to read |
| capture_we | output | 1 | Capture window open |
| buf_full | output | 1 | A complete burst is held |

## Verification
The bench builds the block with DEPTH = 16 and keeps the default 3-bit rate select, so a single burst lasts 16 to 2048 cycles. This lets every one of the eight divider ratios be swept with complete drains of both channels. The channel inputs follow a free-running cycle count, so the bench can work out each stored word arithmetically from the start edge and the ratio. That exposes any off-by-one in strobe phase, in write order, or in the edge where capture stops. The small depth also makes it cheap to repeat the trigger-mode sequences: arming, an unarmed pulse, a pulse while full, periodic re-arm and a clear in the middle of a burst.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    TM_MANUAL   = 2'd0,
    TM_SINGLE   = 2'd1,
    TM_PERIODIC = 2'd2,
    TM_SPARE    = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_HOLD    = 2'd2
  } cap_state_e;

  // Sample ratio for a divider exponent.
  function automatic int unsigned rate_ratio(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // Modes in which the comparator, not the host, starts a burst.
  function automatic logic is_trig_mode(input trig_mode_e m);
    return (m == TM_SINGLE) || (m == TM_PERIODIC);
  endfunction

  // Whether a comparator edge may be latched in the given mode.
  function automatic logic trig_allowed(input trig_mode_e m, input logic armed);
    return (m == TM_PERIODIC) || ((m == TM_SINGLE) && armed);
  endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import cap_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] sel,
  output logic              strobe
);

  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit  = CNT_W'(rate_ratio(32'(sel)) - 1);
    strobe = run && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (strobe)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/chan_buffer.sv
module chan_buffer #(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16,
  parameter int DEPTH    = 2048
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_sample,
  input  logic                rd_en,
  output logic [WORD_W-1:0]   rd_word,
  output logic                at_last,
  output logic                drained
);

  // DEPTH is a power of two.
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CW-1:0]     wr_cnt;
  logic [CW-1:0]     rd_cnt;
  logic              filled;

  always_comb begin
    filled  = (wr_cnt == CW'(DEPTH));
    at_last = (wr_cnt == CW'(DEPTH - 1));
    drained = (rd_cnt == wr_cnt);
    rd_word = mem[rd_cnt[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en && !filled)
      mem[wr_cnt[AW-1:0]] <= {{(WORD_W - SAMPLE_W){1'b0}}, wr_sample};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      if (wr_en && !filled) wr_cnt <= wr_cnt + 1'b1;
      if (rd_en && !drained) rd_cnt <= rd_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       host_start,
  input  logic       trig_in,
  input  logic       clear,
  input  logic       fill_done,
  input  logic       all_drained,
  output cap_state_e state,
  output logic       trig_latched
);

  logic idle;
  logic armed;
  logic accept;
  logic go;

  always_comb begin
    idle   = (state == ST_IDLE);
    accept = idle && trig_in && trig_allowed(mode, armed);
    go     = idle && (is_trig_mode(mode) ? trig_latched : host_start);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (go)          state <= ST_CAPTURE;
        ST_CAPTURE: if (fill_done)   state <= ST_HOLD;
        ST_HOLD:    if (all_drained) state <= ST_IDLE;
        default:                     state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)                             armed <= 1'b0;
    else if (go)                                     armed <= 1'b0;
    else if (idle && mode == TM_SINGLE && host_start) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear || fill_done) trig_latched <= 1'b0;
    else if (accept)                  trig_latched <= 1'b1;
  end

endmodule

// File: rtl/burst_capture_ctrl.sv
module burst_capture_ctrl
  import cap_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16,
  parameter int DEPTH    = 2048,
  parameter int RATE_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                dual_en,
  input  logic [RATE_W-1:0]   rate_sel,
  input  logic                host_start,
  input  logic                trig_in,
  input  logic                clear,
  input  logic [SAMPLE_W-1:0] ch_a_in,
  input  logic [SAMPLE_W-1:0] ch_b_in,
  input  logic                rd_req,
  input  logic                rd_sel,
  output logic [WORD_W-1:0]   rd_data,
  output logic                rd_empty,
  output logic                capture_we,
  output logic                buf_full
);

  localparam int NCH = 2;

  cap_state_e state;
  logic       trig_latched;
  logic       smp_strobe;
  logic       fill_done;
  logic       all_drained;
  logic       flush_w;
  logic       idle_w;
  logic       dual_q;

  logic [NCH-1:0]      wr_en_v;
  logic [NCH-1:0]      rd_en_v;
  logic [NCH-1:0]      at_last_v;
  logic [NCH-1:0]      drained_v;
  logic [SAMPLE_W-1:0] samp_v [NCH];
  logic [WORD_W-1:0]   word_v [NCH];

  always_comb begin
    idle_w      = (state == ST_IDLE);
    capture_we  = (state == ST_CAPTURE);
    buf_full    = (state == ST_HOLD);
    all_drained = &drained_v;
    flush_w     = clear || (buf_full && all_drained);
    fill_done   = smp_strobe && at_last_v[0] && (at_last_v[1] || !dual_q);
    samp_v[0]   = ch_a_in;
    samp_v[1]   = ch_b_in;
    wr_en_v[0]  = smp_strobe;
    wr_en_v[1]  = smp_strobe && dual_q;
    rd_en_v[0]  = rd_req && buf_full && !rd_sel;
    rd_en_v[1]  = rd_req && buf_full && rd_sel;
    rd_data     = word_v[rd_sel];
    rd_empty    = !buf_full || drained_v[rd_sel];
  end

  // Channel selection follows dual_en until a burst starts, then holds.
  always_ff @(posedge clk) begin
    if (!rst_n)      dual_q <= 1'b0;
    else if (idle_w) dual_q <= dual_en;
  end

  rate_divider #(.RATE_W(RATE_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (capture_we),
    .sel    (rate_sel),
    .strobe (smp_strobe)
  );

  trig_ctrl u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (trig_mode_e'(mode)),
    .host_start   (host_start),
    .trig_in      (trig_in),
    .clear        (clear),
    .fill_done    (fill_done),
    .all_drained  (all_drained),
    .state        (state),
    .trig_latched (trig_latched)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_buffer #(
      .SAMPLE_W (SAMPLE_W),
      .WORD_W   (WORD_W),
      .DEPTH    (DEPTH)
    ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_w),
      .wr_en     (wr_en_v[c]),
      .wr_sample (samp_v[c]),
      .rd_en     (rd_en_v[c]),
      .rd_word   (word_v[c]),
      .at_last   (at_last_v[c]),
      .drained   (drained_v[c])
    );
  end

endmodule

// File: rtl/capture_ctrl_chk.sv
module capture_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       capture_we,
  input logic       buf_full,
  input logic       rd_empty,
  input logic       strobe,
  input logic       idle,
  input logic       trig_latched
);

  // R6: no writing once the burst is complete
  assert_we_off_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !capture_we);

  // R3: divider strobes only inside the capture window
  assert_strobe_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> capture_we);

  // R2: a capture only opens out of the empty state
  assert_start_from_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_we) |-> $past(idle));

  // R8: latched trigger consumed when the burst completes
  assert_latch_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> !trig_latched);

  // R2: manual mode never latches the comparator
  assert_manual_no_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !trig_latched) |=> !trig_latched);

  // R10: nothing to read outside the held state
  assert_empty_outside_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_full |-> rd_empty);

endmodule

bind burst_capture_ctrl capture_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .capture_we   (capture_we),
  .buf_full     (buf_full),
  .rd_empty     (rd_empty),
  .strobe       (smp_strobe),
  .idle         (idle_w),
  .trig_latched (trig_latched)
);

// File: tb/tb_burst_capture_ctrl.sv
`timescale 1ns/1ps
module tb_burst_capture_ctrl;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dual_en = 1'b0;
  logic [2:0]  rate_sel = 3'd0;
  logic        host_start = 1'b0;
  logic        trig_in = 1'b0;
  logic        clear = 1'b0;
  logic        rd_req = 1'b0;
  logic        rd_sel = 1'b0;
  logic [11:0] ch_a_in;
  logic [11:0] ch_b_in;
  logic [15:0] rd_data;
  logic        rd_empty;
  logic        capture_we;
  logic        buf_full;

  logic [31:0] tcount = 32'd0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) tcount <= tcount + 1;
  assign ch_a_in = tcount[11:0];
  assign ch_b_in = ~tcount[11:0];

  burst_capture_ctrl #(.DEPTH(N)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dual_en(dual_en), .rate_sel(rate_sel),
    .host_start(host_start), .trig_in(trig_in), .clear(clear),
    .ch_a_in(ch_a_in), .ch_b_in(ch_b_in), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_empty(rd_empty), .capture_we(capture_we), .buf_full(buf_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int base, input int d, input int k, input bit chb);
    logic [11:0] v;
    v = 12'(base + (k + 1) * d);
    if (chb) v = ~v;
    return {4'h0, v};
  endfunction

  task automatic run_capture(input logic [1:0] m, input int r, input bit dual,
                             input bit via_trig, output int base);
    int d;
    int off;
    d   = 1 << r;
    off = via_trig ? 1 : 0;
    @(negedge clk);
    mode = m; rate_sel = 3'(r); dual_en = dual;
    if (via_trig) trig_in = 1'b1; else host_start = 1'b1;
    base = int'(tcount) + 1 + off;
    @(negedge clk);
    trig_in = 1'b0; host_start = 1'b0;
    if (via_trig) chk("R7 window opens one cycle after latch", capture_we, 0);
    else          chk("R2 manual start opens window", capture_we, 1);
    repeat (N * d - 1 + off) @(negedge clk);
    chk("R6 still capturing before last sample", {buf_full, capture_we}, 2'b01);
    @(negedge clk);
    chk("R6 full after last sample", {buf_full, capture_we}, 2'b10);
  endtask

  task automatic drain(input bit dual, input int base, input int r);
    int d;
    d = 1 << r;
    if (!dual) begin
      @(negedge clk); rd_sel = 1'b1; #1;
      chk("R5 channel B empty in single mode", rd_empty, 1);
    end
    for (int c = 0; c < (dual ? 2 : 1); c++) begin
      for (int k = 0; k < N; k++) begin
        @(negedge clk);
        rd_sel = c[0]; rd_req = 1'b0; #1;
        chk("R10 word available", rd_empty, 0);
        chk("R4 stored word (R3 strobe phase, R5 alignment)", rd_data, exp_word(base, d, k, c[0]));
        rd_req = 1'b1;
      end
      @(negedge clk); rd_req = 1'b0; #1;
      chk("R10 channel drained", rd_empty, 1);
      if (dual && c == 0) chk("R11 held until B drained", buf_full, 1);
    end
    @(negedge clk);
    chk("R11 empty after full drain", buf_full, 0);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 reset capture_we", capture_we, 0);
    chk("R1 reset buf_full", buf_full, 0);
    chk("R1 reset rd_empty", rd_empty, 1);
    rst_n = 1'b1;

    // Manual sweep over every divider ratio, both channels
    for (int r = 0; r < 8; r++) begin
      run_capture(2'd0, r, 1'b1, 1'b0, base);
      drain(1'b1, base, r);
    end

    // Single-channel capture
    run_capture(2'd3, 1, 1'b0, 1'b0, base);
    drain(1'b0, base, 1);

    // Manual ignores the comparator
    @(negedge clk); mode = 2'd0;
    pulse_trig();
    repeat (5) @(negedge clk);
    chk("R2 trigger ignored in manual", {buf_full, capture_we}, 2'b00);

    // Single-trigger mode: unarmed trigger ignored
    @(negedge clk); mode = 2'd1;
    pulse_trig();
    repeat (5) @(negedge clk);
    chk("R7 unarmed trigger ignored", {buf_full, capture_we}, 2'b00);
    @(negedge clk); host_start = 1'b1;
    @(negedge clk); host_start = 1'b0;
    run_capture(2'd1, 2, 1'b1, 1'b1, base);
    drain(1'b1, base, 2);
    pulse_trig();
    repeat (5) @(negedge clk);
    chk("R7 disarmed after capture", {buf_full, capture_we}, 2'b00);

    // Periodic mode with a trigger during hold
    run_capture(2'd2, 0, 1'b1, 1'b1, base);
    pulse_trig();
    chk("R8 trigger while full does not reopen", capture_we, 0);
    drain(1'b1, base, 0);
    repeat (5) @(negedge clk);
    chk("R8 dropped trigger not retained", capture_we, 0);
    run_capture(2'd2, 3, 1'b0, 1'b1, base);
    drain(1'b0, base, 3);
    run_capture(2'd2, 1, 1'b1, 1'b1, base);
    drain(1'b1, base, 1);
    chk("R9 periodic re-armed twice", buf_full, 0);

    // Clear after partial drain
    run_capture(2'd0, 0, 1'b1, 1'b0, base);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); rd_sel = 1'b0; rd_req = 1'b1;
    end
    @(negedge clk); rd_req = 1'b0; #1;
    chk("R11 still full with B unread", buf_full, 1);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0; rd_sel = 1'b1; #1;
    chk("R11 clear empties", {buf_full, rd_empty}, 2'b01);
    run_capture(2'd0, 0, 1'b1, 1'b0, base);
    drain(1'b1, base, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R1..) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule